// File: doc/BRIEF.md
# Prioritised Nested Interrupt Controller

This block sits between a set of peripheral request lines and one processor core. It decides which request, if any, is offered to the core. Each line has four pieces of state: an enable bit, a pending bit, an active bit and an 8-bit priority. From these the controller picks one winning line and presents it as an exception number (line n appears as 16 + n), together with the byte offset of that number's vector slot.

The core answers with two single-cycle handshakes. `ack_entry` says the handler for the presented line has started. `ack_exit` says the innermost running handler has returned. Nesting is allowed. A pending line interrupts a running handler only when it is strictly more urgent than every line that is already active. Delivery is also gated by two masks: a global mask that blocks everything, and a priority threshold that blocks only the less urgent lines.

Software reaches the state through a small word-addressed register port. Enable and pending bits have separate set and clear addresses, so a single bit can be changed without a read-modify-write.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req` is 0. All enable, pending and active bits are 0, every priority is 0, and the global mask and the threshold are 0.
- R2: A line is never presented unless both its enable bit and its pending bit are 1. A pending line whose enable bit is 0 stays pending and is not delivered.
- R3: A line's pending bit becomes 1 on the clock edge that samples its request high while the line is not active. The pending bit is cleared on the edge where `ack_entry` is taken for that line.
- R4: `ack_entry` while `irq_req` is 1 sets the active bit of the presented line. `ack_exit` clears the active bit of the most urgent active line only.
- R5: Among the enabled pending lines, the one with the numerically lowest priority wins. When priorities are equal, the lower line number wins.
- R6: While `irq_req` is 1, `irq_num` equals 16 + n for winning line n, and `vec_offset` equals 4 × `irq_num`. With the default of 52 lines, line 51 gives 67 and 268.
- R7: While the global mask bit is 1, `irq_req` stays 0 for every line. Clearing the mask bit restores delivery.
- R8: When the threshold T is not 0, a line whose priority is greater than T is blocked, and priorities less than or equal to T pass. T = 0 turns this masking off.
- R9: A pending line is delivered while another line is active only if its priority is strictly lower in value than the active line's priority. Equal priority does not preempt.
- R10: If a line's request is still high on the edge where its handler exits, the pending bit is set on that same edge and the line is presented again at once.
- R11: A write to a set address sets exactly the bits written as 1. A write to a clear address clears exactly the bits written as 1. Bits written as 0 keep their value. A clear and a set of the same pending bit by request in one cycle leaves it cleared.
- R12: Register address layout: `reg_addr[8:6]` selects the region and `reg_addr[5:0]` the word. The regions are 0 enable-set, 1 enable-clear, 2 pending-set and 3 pending-clear; each of these holds 32 lines per word, and both addresses of a pair read back the current bits. Region 4 is active (read only). Region 5 holds priorities, four lines per word, with line 4w+k in byte k. Region 6 word 0 bit 0 is the global mask, and region 6 word 1 bits 7:0 are the threshold. Bits for lines that do not exist read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | N_LINES | Level request from each peripheral line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address (region and word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| ack_entry | input | 1 | Core has entered the handler of the presented line |
| ack_exit | input | 1 | Core has left the innermost handler |
| irq_req | output | 1 | An interrupt is being presented |
| irq_num | output | EXC_W | Exception number of the presented line (16 + n) |
| vec_offset | output | EXC_W+2 | Byte offset of the vector slot (4 × `irq_num`) |

## Verification
Faults in the per-line state registers show up at the ports on the very next edge. A pending bit that is not set, or not cleared, either fails to raise `irq_req` or presents a line that has already been entered. A lost active bit lets an equal-priority line nest, or makes `ack_exit` retire the wrong handler, and this becomes visible in the active word read back right after the exit. Priority or tie-break faults change `irq_num` in the same cycle the priority register is written. A threshold or mask compare that is off by one is caught by putting an equal priority right at the boundary.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int DATA_W         = 32;
    localparam int PRIO_W         = 8;
    localparam int REGION_W       = 3;
    localparam int REG_IDX_W      = 6;
    localparam int REG_ADDR_W     = REGION_W + REG_IDX_W;
    localparam int LINE_IDX_W     = 9;
    localparam int EXC_BASE       = 16;
    localparam int PRIOS_PER_WORD = DATA_W / PRIO_W;

    // Register regions, selected by the top address bits
    typedef enum logic [REGION_W-1:0] {
        RG_EN_SET = 3'd0,
        RG_EN_CLR = 3'd1,
        RG_PD_SET = 3'd2,
        RG_PD_CLR = 3'd3,
        RG_ACT    = 3'd4,
        RG_PRIO   = 3'd5,
        RG_CTRL   = 3'd6,
        RG_RSVD   = 3'd7
    } region_e;

    // One arbitration candidate
    typedef struct packed {
        logic                  valid;
        logic [PRIO_W-1:0]     prio;
        logic [LINE_IDX_W-1:0] idx;
    } cand_t;

    // Pick the more urgent of two candidates; `lo` holds the lower line
    // numbers, so it wins ties.
    function automatic cand_t pick(cand_t lo, cand_t hi);
        if (lo.valid && (!hi.valid || lo.prio <= hi.prio))
            return lo;
        return hi;
    endfunction

endpackage

// File: rtl/nic_line_bank.sv
module nic_line_bank
    import nic_pkg::*;
#(
    parameter int N_LINES = 52
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req,
    input  logic [N_LINES-1:0] en_set,
    input  logic [N_LINES-1:0] en_clr,
    input  logic [N_LINES-1:0] pd_set,
    input  logic [N_LINES-1:0] pd_clr,
    input  logic [N_LINES-1:0] enter_hot,
    input  logic [N_LINES-1:0] leave_hot,
    output logic [N_LINES-1:0] ena,
    output logic [N_LINES-1:0] pend,
    output logic [N_LINES-1:0] act
);

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        logic ena_q, pend_q, act_q;
        logic hw_set;

        // A level request marks the line pending when it is idle, or on the
        // very edge its handler leaves.
        assign hw_set = req[n] && (!act_q || leave_hot[n]);

        always_ff @(posedge clk) begin
            if (rst) begin
                ena_q  <= 1'b0;
                pend_q <= 1'b0;
                act_q  <= 1'b0;
            end else begin
                if (en_clr[n])
                    ena_q <= 1'b0;
                else if (en_set[n])
                    ena_q <= 1'b1;

                if (enter_hot[n] || pd_clr[n])
                    pend_q <= 1'b0;
                else if (pd_set[n] || hw_set)
                    pend_q <= 1'b1;

                if (enter_hot[n])
                    act_q <= 1'b1;
                else if (leave_hot[n])
                    act_q <= 1'b0;
            end
        end

        assign ena[n]  = ena_q;
        assign pend[n] = pend_q;
        assign act[n]  = act_q;
    end

endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_pkg::*;
#(
    parameter int N_LINES = 52
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  region_e              region,
    input  logic [REG_IDX_W-1:0] widx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [PRIO_W-1:0]    prio [N_LINES],
    output logic                 gmask,
    output logic [PRIO_W-1:0]    thresh
);

    localparam int PRIO_WORDS = (N_LINES + PRIOS_PER_WORD - 1) / PRIOS_PER_WORD;

    logic prio_we;
    assign prio_we = reg_we && (region == RG_PRIO) && (int'(widx) < PRIO_WORDS);

    for (genvar n = 0; n < N_LINES; n++) begin : g_prio
        localparam int WI = n / PRIOS_PER_WORD;
        localparam int SL = n % PRIOS_PER_WORD;
        logic [PRIO_W-1:0] prio_q;

        always_ff @(posedge clk) begin
            if (rst)
                prio_q <= '0;
            else if (prio_we && widx == REG_IDX_W'(WI))
                prio_q <= wdata[SL*PRIO_W +: PRIO_W];
        end

        assign prio[n] = prio_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gmask  <= 1'b0;
            thresh <= '0;
        end else if (reg_we && region == RG_CTRL) begin
            if (widx == REG_IDX_W'(0))
                gmask <= wdata[0];
            if (widx == REG_IDX_W'(1))
                thresh <= wdata[PRIO_W-1:0];
        end
    end

endmodule

// File: rtl/nic_min_arb.sv
module nic_min_arb
    import nic_pkg::*;
#(
    parameter int N_LINES = 52
) (
    input  logic [N_LINES-1:0] valid,
    input  logic [PRIO_W-1:0]  prio [N_LINES],
    output cand_t              win
);

    localparam int LEVELS = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam int LEAVES = 1 << LEVELS;

    cand_t work [LEAVES];

    // Balanced reduction tree, done in place: at each level slot i takes the
    // better of slots 2i and 2i+1, so lower line numbers stay on the left.
    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            if (i < N_LINES) begin
                work[i].valid = valid[i];
                work[i].prio  = prio[i];
                work[i].idx   = LINE_IDX_W'(i);
            end else begin
                work[i] = '0;
            end
        end
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            for (int i = 0; i < (LEAVES >> (lvl + 1)); i++)
                work[i] = pick(work[2*i], work[2*i+1]);
        end
        win = work[0];
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter  int N_LINES = 52,
    localparam int EXC_W   = $clog2(N_LINES + EXC_BASE)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_LINES-1:0]    irq_line,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  ack_entry,
    input  logic                  ack_exit,
    output logic                  irq_req,
    output logic [EXC_W-1:0]      irq_num,
    output logic [EXC_W+1:0]      vec_offset
);

    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    region_e              region;
    logic [REG_IDX_W-1:0] ridx;

    assign region = region_e'(reg_addr[REG_ADDR_W-1 -: REGION_W]);
    assign ridx   = reg_addr[REG_IDX_W-1:0];

    logic [N_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [N_LINES-1:0] enter_hot, leave_hot;
    logic [N_LINES-1:0] ena, pend, act, ready;
    logic [PRIO_W-1:0]  prio [N_LINES];
    logic               gmask;
    logic [PRIO_W-1:0]  thresh;
    cand_t              pend_win, act_win;

    // Per-line write decode and the handshake steering
    for (genvar n = 0; n < N_LINES; n++) begin : g_dec
        localparam int WB = n / DATA_W;
        localparam int BB = n % DATA_W;
        logic hit;

        assign hit          = reg_we && (ridx == REG_IDX_W'(WB)) && reg_wdata[BB];
        assign en_set[n]    = hit && (region == RG_EN_SET);
        assign en_clr[n]    = hit && (region == RG_EN_CLR);
        assign pd_set[n]    = hit && (region == RG_PD_SET);
        assign pd_clr[n]    = hit && (region == RG_PD_CLR);
        assign enter_hot[n] = ack_entry && irq_req && (pend_win.idx == LINE_IDX_W'(n));
        assign leave_hot[n] = ack_exit && act_win.valid && (act_win.idx == LINE_IDX_W'(n));
    end

    nic_line_bank #(.N_LINES(N_LINES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .req       (irq_line),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .enter_hot (enter_hot),
        .leave_hot (leave_hot),
        .ena       (ena),
        .pend      (pend),
        .act       (act)
    );

    nic_cfg_regs #(.N_LINES(N_LINES)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .reg_we (reg_we),
        .region (region),
        .widx   (ridx),
        .wdata  (reg_wdata),
        .prio   (prio),
        .gmask  (gmask),
        .thresh (thresh)
    );

    assign ready = pend & ena;

    nic_min_arb #(.N_LINES(N_LINES)) u_pend_arb (
        .valid (ready),
        .prio  (prio),
        .win   (pend_win)
    );

    // The most urgent active line sets the running level and is the one
    // retired by an exit handshake.
    nic_min_arb #(.N_LINES(N_LINES)) u_act_arb (
        .valid (act),
        .prio  (prio),
        .win   (act_win)
    );

    logic pass_thr, pass_nest;

    assign pass_thr   = (thresh == '0) || (pend_win.prio <= thresh);
    assign pass_nest  = !act_win.valid || (pend_win.prio < act_win.prio);
    assign irq_req    = pend_win.valid && !gmask && pass_thr && pass_nest;
    assign irq_num    = irq_req ? (EXC_W'(pend_win.idx) + EXC_W'(EXC_BASE)) : '0;
    assign vec_offset = {irq_num, 2'b00};

    // Read path
    function automatic logic [DATA_W-1:0] bit_word(input logic [N_LINES-1:0] v,
                                                   input logic [REG_IDX_W-1:0] w);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (int'(w) * DATA_W + b < N_LINES)
                r[b] = v[LW'(int'(w) * DATA_W + b)];
        end
        return r;
    endfunction

    always_comb begin
        reg_rdata = '0;
        case (region)
            RG_EN_SET, RG_EN_CLR: reg_rdata = bit_word(ena, ridx);
            RG_PD_SET, RG_PD_CLR: reg_rdata = bit_word(pend, ridx);
            RG_ACT:               reg_rdata = bit_word(act, ridx);
            RG_PRIO: begin
                for (int s = 0; s < PRIOS_PER_WORD; s++) begin
                    if (int'(ridx) * PRIOS_PER_WORD + s < N_LINES)
                        reg_rdata[s*PRIO_W +: PRIO_W] =
                            prio[LW'(int'(ridx) * PRIOS_PER_WORD + s)];
                end
            end
            RG_CTRL: begin
                if (ridx == REG_IDX_W'(0))
                    reg_rdata[0] = gmask;
                else if (ridx == REG_IDX_W'(1))
                    reg_rdata[PRIO_W-1:0] = thresh;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
#(
    parameter int N_LINES = 52,
    parameter int EXC_W   = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               ack_entry,
    input logic               ack_exit,
    input logic               irq_req,
    input logic [EXC_W-1:0]   irq_num,
    input logic [N_LINES-1:0] ena,
    input logic [N_LINES-1:0] pend,
    input logic [N_LINES-1:0] act,
    input logic               gmask,
    input logic [PRIO_W-1:0]  thresh,
    input cand_t              pend_win,
    input cand_t              act_win
);

    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    logic [LW-1:0] cur_line, last_line;

    assign cur_line = LW'(irq_num - EXC_W'(EXC_BASE));

    always_ff @(posedge clk) last_line <= cur_line;

    // R2: only enabled pending lines are presented
    p_line_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (ena[cur_line] && pend[cur_line]));

    // R3 and R4: entry moves the line from pending to active
    p_entry_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (ack_entry && irq_req && !ack_exit) |=> (!pend[last_line] && act[last_line]));

    // R6: presented number lies in the external range
    p_num_range_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_num >= EXC_W'(EXC_BASE) && int'(irq_num) < EXC_BASE + N_LINES));

    // R7: global mask blocks everything
    p_gmask_block_r7: assert property (@(posedge clk) disable iff (rst)
        gmask |-> !irq_req);

    // R8: threshold blocks less urgent lines
    p_thresh_block_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_req && thresh != '0) |-> (pend_win.prio <= thresh));

    // R9: nesting only for strictly more urgent lines
    p_nest_strict_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && act_win.valid) |-> (pend_win.prio < act_win.prio));

endmodule

bind nest_irq_ctrl nic_checker #(.N_LINES(N_LINES), .EXC_W(EXC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack_entry (ack_entry),
    .ack_exit  (ack_exit),
    .irq_req   (irq_req),
    .irq_num   (irq_num),
    .ena       (ena),
    .pend      (pend),
    .act       (act),
    .gmask     (gmask),
    .thresh    (thresh),
    .pend_win  (pend_win),
    .act_win   (act_win)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 52;
    localparam int EW         = 7;

    localparam int EN_SET = 0, EN_CLR = 1, PD_SET = 2, PD_CLR = 3;
    localparam int ACT = 4, PRIO = 5, CTRL = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_line = '0;
    logic          reg_we = 1'b0;
    logic [8:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ack_entry = 1'b0;
    logic          ack_exit = 1'b0;
    logic          irq_req;
    logic [EW-1:0] irq_num;
    logic [EW+1:0] vec_offset;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    nest_irq_ctrl #(.N_LINES(N)) u0 (
        .clk(clk), .rst(rst), .irq_line(irq_line),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_entry(ack_entry), .ack_exit(ack_exit),
        .irq_req(irq_req), .irq_num(irq_num), .vec_offset(vec_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, longint actual, longint expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
        end
    endtask

    task automatic wr(int region, int idx, logic [31:0] data);
        reg_we    = 1'b1;
        reg_addr  = {3'(region), 6'(idx)};
        reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(int region, int idx, output logic [31:0] d);
        reg_addr = {3'(region), 6'(idx)};
        #1;
        d = reg_rdata;
    endtask

    task automatic do_entry();
        ack_entry = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_entry = 1'b0;
        #1;
    endtask

    task automatic do_exit();
        ack_exit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_exit = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_req after reset", irq_req, 0);
        rd(EN_SET, 0, d); chk("R1 enable word0", d, 0);
        rd(PD_SET, 1, d); chk("R1 pending word1", d, 0);
        rd(PRIO, 0, d);   chk("R1 priority word0", d, 0);
        rd(CTRL, 1, d);   chk("R1 threshold", d, 0);
    endtask

    task automatic t_enable_gate();
        logic [31:0] d;
        irq_line[5] = 1'b1;
        @(posedge clk); @(negedge clk); #1;
        rd(PD_SET, 0, d);
        chk("R3 pending set by request", d, 32'h20);
        chk("R2 disabled line not presented", irq_req, 0);
        wr(EN_SET, 0, 32'h20);
        chk("R2 enabled line presented", irq_req, 1);
        chk("R6 irq_num for line 5", irq_num, 21);
        chk("R6 vec_offset for line 5", vec_offset, 84);
    endtask

    task automatic t_entry_exit();
        logic [31:0] d;
        do_entry();
        rd(PD_SET, 0, d); chk("R3 pending cleared at entry", d, 0);
        rd(ACT, 0, d);    chk("R4 active set at entry", d, 32'h20);
        chk("R3 no re-present while active", irq_req, 0);
        irq_line[5] = 1'b0;
        do_exit();
        rd(ACT, 0, d);    chk("R4 active cleared at exit", d, 0);
        rd(PD_SET, 0, d); chk("R10 dropped request does not re-pend", d, 0);
    endtask

    task automatic t_refire();
        logic [31:0] d;
        irq_line[7] = 1'b1;
        wr(EN_SET, 0, 32'h80);
        chk("R10 level line presented", irq_num, 23);
        do_entry();
        chk("R10 not presented while in handler", irq_req, 0);
        do_exit();
        chk("R10 re-fires right after exit", irq_req, 1);
        chk("R10 re-fire number", irq_num, 23);
        irq_line[7] = 1'b0;
        wr(PD_CLR, 0, 32'h80);
        rd(PD_SET, 0, d); chk("R11 W1C clears pending", d, 0);
        chk("R11 nothing presented after clear", irq_req, 0);
        rd(EN_CLR, 0, d); chk("R11 enables kept by W1C pending", d, 32'hA0);
    endtask

    task automatic t_priority();
        wr(EN_SET, 0, 32'h8);
        wr(EN_SET, 1, 32'h100);
        wr(PRIO, 0, 32'h4000_0000);
        wr(PRIO, 10, 32'h0000_0010);
        wr(PD_SET, 0, 32'h8);
        wr(PD_SET, 1, 32'h100);
        chk("R5 lower priority value wins", irq_num, 56);
        wr(PRIO, 0, 32'h1000_0000);
        chk("R5 tie goes to lower line", irq_num, 19);
    endtask

    task automatic t_nesting();
        logic [31:0] d;
        do_entry();
        chk("R9 equal priority does not preempt", irq_req, 0);
        wr(PRIO, 10, 32'h0000_0008);
        chk("R9 more urgent line preempts", irq_req, 1);
        chk("R9 preempting number", irq_num, 56);
        do_entry();
        rd(ACT, 1, d); chk("R4 nested active word1", d, 32'h100);
        do_exit();
        rd(ACT, 1, d); chk("R4 exit retires most urgent", d, 0);
        rd(ACT, 0, d); chk("R4 outer handler still active", d, 32'h8);
        do_exit();
        rd(ACT, 0, d); chk("R4 outer handler retired", d, 0);
        chk("R4 nothing left to present", irq_req, 0);
    endtask

    task automatic t_masks();
        wr(EN_SET, 0, 32'h400);
        wr(PRIO, 2, 32'h0020_0000);
        wr(PD_SET, 0, 32'h400);
        chk("R7 presented before mask", irq_num, 26);
        wr(CTRL, 0, 32'h1);
        chk("R7 global mask blocks", irq_req, 0);
        wr(CTRL, 0, 32'h0);
        chk("R7 unmask restores", irq_req, 1);
        wr(CTRL, 1, 32'h10);
        chk("R8 less urgent than threshold blocked", irq_req, 0);
        wr(CTRL, 1, 32'h20);
        chk("R8 equal to threshold passes", irq_req, 1);
        wr(CTRL, 1, 32'h1F);
        chk("R8 one above threshold blocked", irq_req, 0);
        wr(CTRL, 1, 32'h0);
        chk("R8 zero threshold disables masking", irq_req, 1);
        wr(PD_CLR, 0, 32'h400);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(EN_CLR, 0, 32'h400);
        rd(EN_SET, 0, d); chk("R11 W1C leaves other enables", d, 32'hA8);
        wr(EN_SET, 0, 32'h0);
        rd(EN_SET, 0, d); chk("R11 zero W1S changes nothing", d, 32'hA8);
        wr(EN_SET, 1, 32'hFFFF_FFFF);
        rd(EN_SET, 1, d); chk("R12 missing lines read zero", d, 32'h000F_FFFF);
        wr(PD_SET, 1, 32'h0008_0000);
        chk("R6 last line number", irq_num, 67);
        chk("R6 last line offset", vec_offset, 268);
        rd(PRIO, 12, d);  chk("R12 priority word layout", d, 0);
        wr(PRIO, 12, 32'h0300_0000);
        rd(PRIO, 12, d);  chk("R12 priority byte for line 51", d, 32'h0300_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_enable_gate();
        t_entry_exit();
        t_refire();
        t_priority();
        t_nesting();
        t_masks();
        t_regs();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule